// File: doc/BRIEF.md
# Line-Buffered Debug Log Sink

The block collects single-byte writes from a host bus into an internal character store and releases them as complete text messages on a byte stream. A message is released when the host writes a newline, or when the store can take no more text. Each message ends with a zero byte that carries the stream's last flag. The newline is not part of the message. A write that arrives on a full store starts a release and is dropped.

While a message drains, the block lowers its write-ready output. A host that holds its strobe and data until ready returns loses nothing. The receiver paces the drain through the stream's ready input. Capacity is a parameter, and one slot of it is always kept for the terminator, so a message carries at most `DEPTH-1` text bytes.

Top module: `log_line_sink`

## Requirements
- R1: After reset, `wr_ready` is 1 and `msg_valid` is 0.
- R2: A written byte other than 0x0A, accepted while fewer than `DEPTH-1` bytes are held, is kept and later emitted in write order.
- R3: An accepted write of 0x0A starts a release of the held text. The 0x0A byte itself is never emitted.
- R4: An accepted write made while `DEPTH-1` bytes are held starts a release of exactly those bytes. The written byte is discarded.
- R5: Every message ends with a 0x00 byte that has `msg_last` = 1. No other byte has `msg_last` set.
- R6: `wr_ready` is 0 from the cycle after a release starts until the cycle after the terminator is accepted. A write held during that time is accepted afterwards and is not lost.
- R7: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid`, `msg_data` and `msg_last` hold their values on the next cycle.
- R8: Reset discards any partly gathered line.
- R9: Releasing an empty line emits only the terminator byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte written |
| wr_ready | output | 1 | Write accepted when high together with wr_en |
| msg_valid | output | 1 | Output byte valid |
| msg_data | output | 8 | Output byte |
| msg_last | output | 1 | Marks the terminator byte |
| msg_ready | input | 1 | Receiver takes the byte |

## Verification
A wrong fill count shows up in the next message. The message comes out one byte too long or too short, or it releases one write early or late. This appears no later than the next newline or the next capacity overflow. A read pointer or drain state that goes wrong shows in the cycle after a release starts. It appears as bytes in the wrong order, a misplaced last flag, or write-ready that does not come back after the terminator. Sweeping every line length across capacity under irregular receiver stalls reaches each of these.

// File: rtl/log_line_sink.sv
module log_line_sink #(
  parameter int DEPTH = 4096,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       wr_ready,
  output logic       msg_valid,
  output logic [7:0] msg_data,
  output logic       msg_last,
  input  logic       msg_ready
);
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] fill;
  logic [AW-1:0] rd;
  logic          draining;

  wire take   = wr_en && !draining;
  wire flush  = take && (wr_data == 8'h0A || fill == LAST_SLOT);
  wire store  = take && !flush;
  wire at_end = (rd == fill);
  wire pop    = draining && msg_ready;

  assign wr_ready  = !draining;
  assign msg_valid = draining;
  assign msg_last  = draining && at_end;
  assign msg_data  = (!draining || at_end) ? 8'h00 : mem[rd];

  always_ff @(posedge clk) begin
    if (store) mem[fill] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill     <= '0;
      rd       <= '0;
      draining <= 1'b0;
    end else if (flush) begin
      draining <= 1'b1;
      rd       <= '0;
    end else if (store) begin
      fill <= fill + 1'b1;
    end else if (pop) begin
      if (at_end) begin
        draining <= 1'b0;
        fill     <= '0;
      end else begin
        rd <= rd + 1'b1;
      end
    end
  end
endmodule

module log_line_sink_chk #(
  parameter int DEPTH = 4096,
  parameter int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [7:0]    wr_data,
  input logic          wr_ready,
  input logic          msg_valid,
  input logic [7:0]    msg_data,
  input logic          msg_last,
  input logic          msg_ready,
  input logic [AW-1:0] fill
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_data) && $stable(msg_last));
  assert_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> !wr_ready);
  assert_reopen_R6: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_ready && msg_last |=> wr_ready && !msg_valid);
  assert_term_zero_R5: assert property (@(posedge clk) disable iff (rst)
    msg_last |-> msg_valid && msg_data == 8'h00);
  assert_newline_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_ready && wr_data == 8'h0A |=> msg_valid);
  assert_full_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_ready && fill == AW'(DEPTH - 1) |=> msg_valid && $stable(fill));
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> wr_ready && !msg_valid);
endmodule

bind log_line_sink log_line_sink_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
  .msg_valid(msg_valid), .msg_data(msg_data), .msg_last(msg_last),
  .msg_ready(msg_ready), .fill(fill)
);

// File: tb/log_line_sink_tb_top.sv
module log_line_sink_tb_top;
  localparam int DEPTH = 8;

  logic       clk = 0;
  logic       rst = 1;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic       wr_ready, msg_valid, msg_last;
  logic [7:0] msg_data;
  logic       msg_ready = 1;

  int checks = 0, errors = 0, cyc = 0, stall_mode = 0, model_len = 0;
  string tag = "R2";
  logic [8:0] expq [$];
  logic [7:0] line [$];
  logic       held_v = 0;
  logic [8:0] held;

  always #4 clk = ~clk;

  log_line_sink #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready),
    .msg_valid(msg_valid), .msg_data(msg_data), .msg_last(msg_last),
    .msg_ready(msg_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    case (stall_mode)
      0: msg_ready = 1;
      1: msg_ready = (cyc % 3) != 1;
      default: msg_ready = ((cyc * 7) % 5) < 2;
    endcase
  end

  always begin
    @(negedge clk); #3;
    if (!rst) begin
      if (held_v) chk(msg_valid && {msg_last, msg_data} == held, "R7",
                      {msg_valid, msg_last, msg_data}, {1'b1, held});
      held_v = msg_valid && !msg_ready;
      held = {msg_last, msg_data};
      if (msg_valid) chk(!wr_ready, "R6", wr_ready, 0);
      if (msg_valid && msg_ready) begin
        if (expq.size() == 0) chk(0, {tag, " R5"}, {msg_last, msg_data}, 'h1ff);
        else begin
          logic [8:0] e;
          e = expq.pop_front();
          chk({msg_last, msg_data} == e, {tag, " R5"}, {msg_last, msg_data}, e);
        end
      end
    end else held_v = 0;
  end

  task automatic release_model();
    foreach (line[i]) expq.push_back({1'b0, line[i]});
    expq.push_back(9'h100);
    line.delete();
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_data = d;
    while (!wr_ready) @(negedge clk);
    if (d == 8'h0A || line.size() == DEPTH - 1) release_model();
    else line.push_back(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic drain_wait();
    for (int k = 0; k < 200 && (expq.size() != 0 || msg_valid); k++) @(negedge clk);
    chk(expq.size() == 0, {tag, " drain"}, expq.size(), 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #3;
    chk(wr_ready && !msg_valid, "R1", {wr_ready, msg_valid}, 2'b10);

    tag = "R9";
    put(8'h0A);
    drain_wait();

    for (int m = 0; m < 3; m++) begin
      stall_mode = m;
      for (int len = 0; len <= DEPTH + 2; len++) begin
        tag = (len >= DEPTH - 1) ? "R4" : (len == 0 ? "R9" : "R3 R2");
        for (int i = 0; i < len; i++) begin
          logic [7:0] b;
          b = 8'((len * 37 + i * 13 + m * 91 + 1) & 8'hff);
          if (b == 8'h0A) b = 8'h0B;
          put(b);
        end
        put(8'h0A);
        drain_wait();
      end
    end

    tag = "R6";
    stall_mode = 2;
    put(8'h41);
    fork
      put(8'h0A);
      begin repeat (2) @(negedge clk); end
    join
    put(8'h42);
    put(8'h0A);
    drain_wait();

    tag = "R8";
    put(8'h55);
    put(8'h66);
    @(negedge clk); rst = 1; line.delete();
    @(negedge clk); rst = 0;
    put(8'h0A);
    drain_wait();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule